// File: doc/BRIEF.md
# Two-Wire Serial Target with Busy Refusal

This block is the target (slave) side of a two-wire serial bus. Both bus lines are brought in raw and sampled on a fast system clock through a synchronizer. The block finds bus start and stop conditions and decodes the address byte. It then either hands received bytes to a register file or shifts bytes from that register file back out to the bus controller. The block never drives SDA high. It only asserts an active-high enable that an open-drain pad turns into a low level on the wire.

A `busy_in` input marks an internal nonvolatile write. While it is high, the target refuses everything. An address byte gets no acknowledge, and neither does a write data byte that arrives during the busy window. After a refusal the target goes quiet until the next start or stop condition. Once `busy_in` drops, the next transfer is acknowledged normally. The system clock must run at least sixteen times faster than SCL.

Top module: `twowire_target`

## Requirements
- R1: After a synchronous reset, `sda_oe`, `wr_strobe` and `rd_strobe` are all low.
- R2: The first byte after a start condition is taken MSB first: bits 7..1 are the address and bit 0 is the direction (1 = read, 0 = write). If the address equals `DEV_ADDR` and `busy_in` is low, `sda_oe` is held high through the whole high phase of the ninth clock.
- R3: On an address mismatch there is no acknowledge, and later bytes get no acknowledge and no `wr_strobe` until a new start or stop condition.
- R4: In a write transfer, each byte received before the ninth clock appears on `wr_data` with a one-cycle `wr_strobe` and is acknowledged. `wr_first` is high only for the first data byte after the address.
- R5: The number of write bytes between start and stop is not limited, and every byte is delivered in bus order.
- R6: In a read transfer, the target captures `rd_data`, pulses `rd_strobe` for one cycle so the source can advance, and shifts the byte out MSB first. A 0 bit is sent as `sda_oe` high and a 1 bit as `sda_oe` low.
- R7: A controller acknowledge (SDA low on the ninth clock) makes the target load and send the next byte. A controller not-acknowledge makes it release SDA, and no further `rd_strobe` follows.
- R8: While `busy_in` is high, an address byte gets no acknowledge. A write data byte arriving while `busy_in` is high gets no acknowledge and no `wr_strobe`, and the target stays passive afterwards.
- R9: Once `busy_in` returns low, the next addressed transfer is acknowledged normally.
- R10: A repeated start after the ninth clock, in place of a stop, is accepted, and a fresh address byte is decoded.
- R11: `sda_oe` changes only while SCL is low.
- R12: After a stop condition, clock pulses that are not preceded by a start condition are ignored: there is no acknowledge and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the wire |
| busy_in | input | 1 | High while an internal nonvolatile write is running |
| rd_data | input | DATA_W | Next byte to send; captured when a read byte is loaded |
| sda_oe | output | 1 | Pull-down enable for SDA (1 = drive low) |
| wr_strobe | output | 1 | One-cycle pulse: `wr_data` holds a received byte |
| wr_data | output | DATA_W | Last byte received from the controller |
| wr_first | output | 1 | Marks the first data byte of a write transfer |
| rd_strobe | output | 1 | One-cycle pulse: `rd_data` was captured, source may advance |

## Verification
A table of single transfers crosses three inputs: matching and mismatching addresses, both directions, and `busy_in` high or low. This separates an acknowledge caused by the address from one caused by the busy gate. Longer directed transfers follow. A twenty-byte write checks ordering and the first-byte flag. A multi-byte read ends with a controller not-acknowledge and extra clocks, which shows whether the line was really released. Further transfers cover busy rising between write bytes, a write followed by a repeated start into a read, and clocks sent without a start after a stop. These tell the passive states apart from the idle state.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_PASSIVE
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic lvl_prev
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  // synchronizer chain, idle level is high
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain[STAGES-1];
  end

  assign lvl      = chain[STAGES-1];
  assign lvl_prev = prev_q;
endmodule

// File: rtl/tw_bus_cond.sv
module tw_bus_cond (
  input  logic scl_lvl,
  input  logic scl_prev,
  input  logic sda_lvl,
  input  logic sda_prev,
  output logic start,
  output logic stop
);
  logic scl_high;
  assign scl_high = scl_lvl & scl_prev;
  assign start    = scl_high &  sda_prev & ~sda_lvl;
  assign stop     = scl_high & ~sda_prev &  sda_lvl;
endmodule

// File: rtl/tw_proto_fsm.sv
module tw_proto_fsm
  import tw_pkg::*;
#(
  parameter int              ADDR_W   = 7,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_prev,
  input  logic              sda_bit,
  input  logic              start,
  input  logic              stop,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_first,
  output logic              rd_strobe
);
  localparam int                CNT_W     = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  BYTE_BITS = CNT_W'(DATA_W);

  tw_state_e         state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txsh;
  logic              rw;
  logic              first;
  logic              mack;
  logic              scl_rise, scl_fall;

  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      rw        <= 1'b0;
      first     <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_strobe <= 1'b0;
      wr_data   <= '0;
      wr_first  <= 1'b0;
      rd_strobe <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      rd_strobe <= 1'b0;
      if (stop) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[DATA_W-2:0], sda_bit};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BYTE_BITS) begin
              if (shreg[DATA_W-1 -: ADDR_W] == DEV_ADDR && !busy) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                state  <= ST_AACK;
              end else begin
                state  <= ST_PASSIVE;
              end
            end
          end
          ST_AACK, ST_RACK: begin
            if (scl_rise && state == ST_RACK) begin
              mack <= ~sda_bit;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (state == ST_AACK && !rw) begin
                sda_oe <= 1'b0;
                first  <= 1'b1;
                state  <= ST_WDATA;
              end else if (state == ST_AACK || mack) begin
                txsh      <= rd_data;
                sda_oe    <= ~rd_data[DATA_W-1];
                rd_strobe <= 1'b1;
                state     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PASSIVE;
              end
            end
          end
          ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[DATA_W-2:0], sda_bit};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BYTE_BITS) begin
              if (busy) begin
                state <= ST_PASSIVE;
              end else begin
                wr_strobe <= 1'b1;
                wr_data   <= shreg;
                wr_first  <= first;
                first     <= 1'b0;
                sda_oe    <= 1'b1;
                state     <= ST_WACK;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == BYTE_BITS) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                txsh   <= txsh << 1;
                sda_oe <= ~txsh[DATA_W-2];
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R8: an acknowledge is only raised on a decision taken while not busy
  assert_ack_needs_free_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && (state == ST_AACK || state == ST_WACK)) |-> !$past(busy));

  // R11: the pull-down moves only on a low SCL
  assert_oe_moves_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start || stop)) |-> !$past(scl_lvl));

  // R3: a passive target never pulls the line
  assert_passive_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PASSIVE) |-> !sda_oe);

  // R12: idle bus is never pulled
  assert_idle_release_R12: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  // R4: write strobe is a single-cycle pulse
  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);
endmodule

// File: rtl/twowire_target.sv
module twowire_target #(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              busy_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_strobe,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_first,
  output logic              rd_strobe
);
  logic scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic cond_start, cond_stop;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_in), .lvl(scl_lvl), .lvl_prev(scl_prev)
  );

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_in), .lvl(sda_lvl), .lvl_prev(sda_prev)
  );

  tw_bus_cond u_cond (
    .scl_lvl(scl_lvl), .scl_prev(scl_prev),
    .sda_lvl(sda_lvl), .sda_prev(sda_prev),
    .start(cond_start), .stop(cond_stop)
  );

  tw_proto_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .scl_prev(scl_prev), .sda_bit(sda_lvl),
    .start(cond_start), .stop(cond_stop), .busy(busy_in),
    .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .wr_first(wr_first),
    .rd_strobe(rd_strobe)
  );

  // R8: no byte is delivered from a busy decision
  assert_no_busy_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> !$past(busy_in));

  // R6: read strobe is a single-cycle pulse
  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> !rd_strobe);
endmodule

// File: tb/twowire_target_bench.sv
module twowire_target_bench;
  localparam int         Q   = 8;
  localparam logic [6:0] DEV = 7'h2C;
  // fields: [17:11] address, [10] read, [9] busy, [8] expect ack, [7:0] data
  localparam logic [17:0] VECS [0:7] = '{
    {7'h2C, 1'b0, 1'b0, 1'b1, 8'h5A},
    {7'h2D, 1'b0, 1'b0, 1'b0, 8'h33},
    {7'h2C, 1'b1, 1'b0, 1'b1, 8'hC3},
    {7'h2C, 1'b0, 1'b1, 1'b0, 8'h77},
    {7'h2C, 1'b1, 1'b1, 1'b0, 8'h10},
    {7'h2C, 1'b0, 1'b0, 1'b1, 8'h00},
    {7'h2C, 1'b1, 1'b0, 1'b1, 8'h7E},
    {7'h6C, 1'b1, 1'b0, 1'b0, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [7:0] rd_base = 8'h00;
  logic       sda_oe, wr_strobe, wr_first, rd_strobe;
  logic [7:0] wr_data, rd_data;
  wire        sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_viol = 0;
  logic [7:0] wr_log [0:63];
  logic       wf_log [0:63];
  logic       oe_prev = 1'b0;

  assign rd_data = rd_base + rd_cnt[7:0];

  twowire_target #(.DEV_ADDR(DEV)) u_twowire_target (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .busy_in(busy),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .wr_first(wr_first), .rd_strobe(rd_strobe)
  );

  always @(posedge clk) begin
    if (!rst && wr_strobe) begin
      wr_log[wr_cnt[5:0]] <= wr_data;
      wf_log[wr_cnt[5:0]] <= wr_first;
      wr_cnt <= wr_cnt + 1;
    end
    if (!rst && rd_strobe) rd_cnt <= rd_cnt + 1;
  end

  // R11 monitor at the ports
  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl_m) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic m_write(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(1);
    ack = !sda_bus; tick(Q);
    ack = ack && !sda_bus; tick(Q-1);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_read(output logic [7:0] b, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = !give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [17:0] e;
    logic [7:0]  b;
    logic [6:0]  va;
    bit          ack, ack2;
    int          w0, r0;
    string       tag;

    tick(5);
    rst = 1'b0;
    tick(1);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
    chk(wr_strobe == 1'b0 && rd_strobe == 1'b0, "R1 strobes after reset",
        int'({wr_strobe, rd_strobe}), 0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      e    = VECS[v];
      va   = e[17:11];
      busy = e[9];
      tag  = e[9] ? "R8" : ((va != DEV) ? "R3" : "R2");
      tick(4);
      w0 = wr_cnt; r0 = rd_cnt;
      rd_base = e[7:0] - rd_cnt[7:0];
      m_start();
      m_write({va, e[10]}, ack);
      chk(ack == e[8], {tag, " address ack"}, int'(ack), int'(e[8]));
      if (!e[10]) begin
        m_write(e[7:0], ack2);
        chk(ack2 == e[8], {tag, " R4 data ack"}, int'(ack2), int'(e[8]));
        tick(2);
        chk(wr_cnt - w0 == int'(e[8]), {tag, " R4 strobe count"}, wr_cnt - w0, int'(e[8]));
        if (e[8]) begin
          chk(wr_log[w0[5:0]] == e[7:0], "R4 wr_data", int'(wr_log[w0[5:0]]), int'(e[7:0]));
          chk(wf_log[w0[5:0]] == 1'b1, "R4 wr_first", int'(wf_log[w0[5:0]]), 1);
        end
      end else if (e[8]) begin
        m_read(b, 1'b0);
        chk(b == e[7:0], "R6 read byte", int'(b), int'(e[7:0]));
        chk(rd_cnt - r0 == 1, "R6 rd_strobe count", rd_cnt - r0, 1);
      end else begin
        chk(rd_cnt == r0, {tag, " no rd_strobe"}, rd_cnt - r0, 0);
      end
      m_stop();
      busy = 1'b0;
    end

    // R5: long write, order and first flag
    tick(4);
    w0 = wr_cnt;
    m_start();
    m_write({DEV, 1'b0}, ack);
    chk(ack, "R5 address ack", int'(ack), 1);
    for (int k = 0; k < 20; k++) begin
      m_write(8'(k * 13 + 7), ack);
      chk(ack, "R5 byte ack", int'(ack), 1);
    end
    m_stop();
    chk(wr_cnt - w0 == 20, "R5 byte count", wr_cnt - w0, 20);
    for (int k = 0; k < 20; k++) begin
      chk(wr_log[6'(w0 + k)] == 8'(k * 13 + 7), "R5 order",
          int'(wr_log[6'(w0 + k)]), (k * 13 + 7) & 255);
      chk(wf_log[6'(w0 + k)] == (k == 0), "R4 first only on first byte",
          int'(wf_log[6'(w0 + k)]), int'(k == 0));
    end

    // R7: multi-byte read ending with controller NACK
    tick(4);
    r0 = rd_cnt;
    rd_base = 8'h40 - rd_cnt[7:0];
    m_start();
    m_write({DEV, 1'b1}, ack);
    chk(ack, "R7 address ack", int'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      m_read(b, k != 2);
      chk(b == 8'(8'h40 + k), "R7 read sequence", int'(b), 8'h40 + k);
    end
    chk(rd_cnt - r0 == 3, "R7 strobes before NACK", rd_cnt - r0, 3);
    m_read(b, 1'b1);
    chk(b == 8'hFF, "R7 line released after NACK", int'(b), 8'hFF);
    chk(rd_cnt - r0 == 3, "R7 no strobe after NACK", rd_cnt - r0, 3);
    m_stop();

    // R8: busy rises between write bytes
    tick(4);
    w0 = wr_cnt;
    m_start();
    m_write({DEV, 1'b0}, ack);
    m_write(8'h11, ack);
    chk(ack, "R8 byte before busy acked", int'(ack), 1);
    busy = 1'b1;
    m_write(8'h22, ack);
    chk(!ack, "R8 byte during busy refused", int'(ack), 0);
    busy = 1'b0;
    m_write(8'h44, ack);
    chk(!ack, "R8 passive after refusal", int'(ack), 0);
    m_stop();
    chk(wr_cnt - w0 == 1, "R8 only one byte delivered", wr_cnt - w0, 1);

    // R9: resumes once busy is clear
    tick(4);
    m_start();
    m_write({DEV, 1'b0}, ack);
    chk(ack, "R9 acknowledge resumes", int'(ack), 1);
    m_stop();

    // R10: write then repeated start into a read
    tick(4);
    w0 = wr_cnt;
    rd_base = 8'hB5 - rd_cnt[7:0];
    m_start();
    m_write({DEV, 1'b0}, ack);
    m_write(8'h9C, ack);
    chk(ack && wr_log[w0[5:0]] == 8'h9C, "R10 write before restart",
        int'(wr_log[w0[5:0]]), 8'h9C);
    m_start();
    m_write({DEV, 1'b1}, ack);
    chk(ack, "R10 fresh address acked", int'(ack), 1);
    m_read(b, 1'b0);
    chk(b == 8'hB5, "R10 read after restart", int'(b), 8'hB5);
    m_stop();

    // R12: clocks without START after STOP
    tick(4);
    w0 = wr_cnt;
    scl_m = 1'b0; tick(Q);
    m_write({DEV, 1'b0}, ack);
    chk(!ack, "R12 no ack without start", int'(ack), 0);
    m_write(8'h3C, ack);
    chk(!ack && wr_cnt == w0, "R12 no write without start", wr_cnt - w0, 0);
    scl_m = 1'b1; tick(Q);

    chk(oe_viol == 0, "R11 sda_oe changes with SCL high", oe_viol, 0);

    tick(10);
    summary();
    $finish;
  end
endmodule